// File: doc/BRIEF.md
# Program-Order Memory Operation Queue

This block keeps the loads and stores of an out-of-order core in program order and lets them reach the data cache one at a time. An entry is reserved at the tail when a memory operation is dispatched. Its index is handed back to the core, so the address unit and the store-data unit can fill the entry later, in whatever order their operands become ready.

Only the oldest entry may present a request to the cache. A load goes out as soon as its address is known. It then waits for the cache response and for the core's retire signal before it leaves the queue. A store needs its address and its data, and the core must also report that the store is the oldest instruction in its reorder buffer. The store performs and leaves the queue on the cycle the cache accepts it. A flush input empties the queue in one cycle.

Top module: `memop_queue`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `disp_idx` is 0 and `req_valid` is 0.
- R2: Each accepted dispatch takes the tail slot reported on `disp_idx`, and the tail then advances by one modulo DEPTH. Once DEPTH entries are held, `disp_ready` is 0. A dispatch offered while `disp_ready` is 0 is ignored and leaves the tail index unchanged.
- R3: Only the head entry may raise `req_valid`. A younger entry that is ready never produces a request while an older entry has not finished.
- R4: A load at the head (`disp_is_store` = 0 at dispatch) raises `req_valid` with `req_is_store` = 0 and its address as soon as its address has been written. The request holds until the cache accepts it with `req_ready`.
- R5: A store at the head (`disp_is_store` = 1) raises `req_valid` only while its address is written, its data is written and `rob_head` is 1. It presents `req_is_store` = 1, its address and its data.
- R6: A store leaves the queue in the cycle the cache accepts it, and the next entry becomes head on the following cycle.
- R7: An accepted load is not requested again. `rsp_valid` marks it done. `ret_valid` frees a done load at the head, and `ret_valid` on a load that is not done has no effect.
- R8: `flush` discards every entry and returns both pointers to slot 0 on the next cycle.
- R9: Address and data writes target an entry by its index and may arrive in any order across entries. Each request carries the values written to its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all entries |
| disp_valid | input | 1 | Dispatch a memory operation |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_ready | output | 1 | A free slot exists |
| disp_idx | output | IW | Slot given to the next dispatch |
| agu_valid | input | 1 | Address write strobe |
| agu_idx | input | IW | Entry receiving the address |
| agu_addr | input | AW | Effective address |
| sd_valid | input | 1 | Store-data write strobe |
| sd_idx | input | IW | Entry receiving the data |
| sd_data | input | DW | Store data |
| rob_head | input | 1 | Head store is oldest in the reorder buffer |
| req_valid | output | 1 | Cache request from the head entry |
| req_ready | input | 1 | Cache accepts the request |
| req_is_store | output | 1 | Request kind |
| req_addr | output | AW | Request address |
| req_data | output | DW | Store data of the request |
| rsp_valid | input | 1 | Cache response for the outstanding load |
| ret_valid | input | 1 | Core retires the head load |

## Verification
The hardest situation to reach is a younger entry that is fully ready while the head is blocked. The stimulus creates it by writing addresses in reverse program order and by holding `rob_head` low under a ready store that sits in front of a ready load. The queue is also filled, and a dispatch is offered while it is full. A single retire then has to expose whether the tail moved when it should not have. A scoreboard records the expected sequence of cache requests, so any issue that happens out of order or twice shows up as a mismatch.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef enum logic {MQ_LOAD = 1'b0, MQ_STORE = 1'b1} mq_kind_t;

  typedef struct packed {
    logic     live;
    mq_kind_t kind;
    logic     addr_ok;
    logic     data_ok;
    logic     sent;
    logic     done;
  } mq_flags_t;
endpackage

// File: rtl/mq_ptrs.sv
module mq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx,
  output logic          full,
  output logic          empty
);
  logic [IW:0] hd_q, tl_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hd_q <= '0;
      tl_q <= '0;
    end else begin
      if (push) tl_q <= tl_q + 1'b1;
      if (pop)  hd_q <= hd_q + 1'b1;
    end
  end

  assign head_idx = hd_q[IW-1:0];
  assign tail_idx = tl_q[IW-1:0];
  assign empty    = (hd_q == tl_q);
  assign full     = (hd_q[IW] != tl_q[IW]) && (hd_q[IW-1:0] == tl_q[IW-1:0]);
endmodule

// File: rtl/mq_store.sv
module mq_store #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          agu_we,
  input  logic [IW-1:0] agu_idx,
  input  logic [AW-1:0] agu_addr,
  input  logic          sd_we,
  input  logic [IW-1:0] sd_idx,
  input  logic [DW-1:0] sd_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (agu_we) addr_mem[agu_idx] <= agu_addr;
  end

  always_ff @(posedge clk) begin
    if (sd_we) data_mem[sd_idx] <= sd_data;
  end

  assign rd_addr = addr_mem[rd_idx];
  assign rd_data = data_mem[rd_idx];
endmodule

// File: rtl/mq_flags.sv
module mq_flags
  import mq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        alloc,
  input  logic [IW-1:0]               alloc_idx,
  input  mq_kind_t                    alloc_kind,
  input  logic                        agu_we,
  input  logic [IW-1:0]               agu_idx,
  input  logic                        sd_we,
  input  logic [IW-1:0]               sd_idx,
  input  logic [IW-1:0]               head_idx,
  input  logic                        mark_sent,
  input  logic                        mark_done,
  input  logic                        release_head,
  output mq_flags_t [DEPTH-1:0]       flags
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        flags[i] <= '0;
      end else if (alloc && alloc_idx == IW'(i)) begin
        flags[i]      <= '0;
        flags[i].live <= 1'b1;
        flags[i].kind <= alloc_kind;
      end else if (flags[i].live) begin
        if (agu_we && agu_idx == IW'(i))
          flags[i].addr_ok <= 1'b1;
        if (sd_we && sd_idx == IW'(i) && flags[i].kind == MQ_STORE)
          flags[i].data_ok <= 1'b1;
        if (mark_sent && head_idx == IW'(i))
          flags[i].sent <= 1'b1;
        if (mark_done && head_idx == IW'(i))
          flags[i].done <= 1'b1;
        if (release_head && head_idx == IW'(i))
          flags[i].live <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mq_gate.sv
module mq_gate
  import mq_pkg::*;
(
  input  mq_flags_t hf,
  input  logic      empty,
  input  logic      rob_head,
  input  logic      req_ready,
  input  logic      rsp_valid,
  input  logic      ret_valid,
  output logic      req_valid,
  output logic      mark_sent,
  output logic      mark_done,
  output logic      release_head
);
  logic is_st, ops_ok;

  always_comb begin
    is_st  = (hf.kind == MQ_STORE);
    ops_ok = hf.addr_ok && (!is_st || (hf.data_ok && rob_head));
    req_valid    = !empty && hf.live && !hf.sent && ops_ok;
    mark_sent    = req_valid && req_ready;
    mark_done    = rsp_valid && hf.live && !is_st && hf.sent && !hf.done;
    release_head = (mark_sent && is_st) ||
                   (ret_valid && hf.live && !is_st && hf.done);
  end
endmodule

// File: rtl/memop_queue.sv
module memop_queue
  import mq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          disp_valid,
  input  logic          disp_is_store,
  output logic          disp_ready,
  output logic [IW-1:0] disp_idx,
  input  logic          agu_valid,
  input  logic [IW-1:0] agu_idx,
  input  logic [AW-1:0] agu_addr,
  input  logic          sd_valid,
  input  logic [IW-1:0] sd_idx,
  input  logic [DW-1:0] sd_data,
  input  logic          rob_head,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_is_store,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  input  logic          rsp_valid,
  input  logic          ret_valid
);
  logic [IW-1:0] head_idx, tail_idx;
  logic full, empty, push, mark_sent, mark_done, release_head;
  mq_flags_t [DEPTH-1:0] flags;
  mq_flags_t hf;

  assign push       = disp_valid && !full && !flush;
  assign disp_ready = !full;
  assign disp_idx   = tail_idx;

  mq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(release_head),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .empty(empty)
  );

  mq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .agu_we(agu_valid), .agu_idx(agu_idx), .agu_addr(agu_addr),
    .sd_we(sd_valid), .sd_idx(sd_idx), .sd_data(sd_data),
    .rd_idx(head_idx), .rd_addr(req_addr), .rd_data(req_data)
  );

  mq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc(push), .alloc_idx(tail_idx),
    .alloc_kind(disp_is_store ? MQ_STORE : MQ_LOAD),
    .agu_we(agu_valid), .agu_idx(agu_idx),
    .sd_we(sd_valid), .sd_idx(sd_idx),
    .head_idx(head_idx), .mark_sent(mark_sent), .mark_done(mark_done),
    .release_head(release_head), .flags(flags)
  );

  assign hf           = flags[head_idx];
  assign req_is_store = (hf.kind == MQ_STORE);

  mq_gate u_gate (
    .hf(hf), .empty(empty), .rob_head(rob_head), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .ret_valid(ret_valid), .req_valid(req_valid),
    .mark_sent(mark_sent), .mark_done(mark_done), .release_head(release_head)
  );
endmodule

// File: rtl/mq_chk.sv
module mq_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic [IW-1:0] disp_idx,
  input logic          rob_head,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_is_store
);
  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> (disp_ready && !req_valid));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready && !flush) |=> (disp_idx == $past(disp_idx)));

  // R5
  store_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_store) |-> rob_head);

  // R4
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !req_is_store && !flush) |=> req_valid);

  // R7
  single_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_is_store && !flush) |=> !req_valid);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (disp_ready && !req_valid && disp_idx == '0));
endmodule

bind memop_queue mq_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .disp_idx(disp_idx), .rob_head(rob_head),
  .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store)
);

// File: tb/sim_memop_queue.sv
module sim_memop_queue;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rst = 1, flush = 0;
  logic disp_valid = 0, disp_is_store = 0, disp_ready;
  logic [IW-1:0] disp_idx;
  logic agu_valid = 0, sd_valid = 0;
  logic [IW-1:0] agu_idx = '0, sd_idx = '0;
  logic [AW-1:0] agu_addr = '0;
  logic [DW-1:0] sd_data = '0;
  logic rob_head = 0, req_valid, req_ready = 0, req_is_store;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic rsp_valid = 0, ret_valid = 0;

  int checks = 0, errors = 0;
  logic [64:0] expq [$];
  bit done_run = 0;

  always #(CLK_P/2) clk = ~clk;

  memop_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_req(input logic st, input logic [31:0] a, input logic [31:0] d);
    expq.push_back({st, a, d});
  endtask

  task automatic dispatch(input logic st);
    disp_valid = 1; disp_is_store = st; step(); disp_valid = 0;
  endtask

  task automatic wr_addr(input logic [IW-1:0] i, input logic [AW-1:0] a);
    agu_valid = 1; agu_idx = i; agu_addr = a; step(); agu_valid = 0;
  endtask

  task automatic wr_data(input logic [IW-1:0] i, input logic [DW-1:0] d);
    sd_valid = 1; sd_idx = i; sd_data = d; step(); sd_valid = 0;
  endtask

  task automatic respond(); rsp_valid = 1; step(); rsp_valid = 0; endtask
  task automatic retire();  ret_valid = 1; step(); ret_valid = 0; endtask

  // scoreboard monitor: a request seen valid and ready at negedge is accepted at the next edge
  always @(negedge clk) begin
    if (!rst && req_valid && req_ready) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected request actual addr=%0h expected none", req_addr);
      end else begin
        logic [64:0] e;
        e = expq.pop_front();
        if (req_is_store !== e[64] || req_addr !== e[63:32] ||
            (e[64] && req_data !== e[31:0])) begin
          errors++;
          $display("FAIL R9 request actual=%0b/%0h/%0h expected=%0b/%0h/%0h",
                   req_is_store, req_addr, req_data, e[64], e[63:32], e[31:0]);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done_run && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step(); rst = 0;
    // R1 reset state
    chk("R1 disp_ready", 64'(disp_ready), 1);
    chk("R1 disp_idx", 64'(disp_idx), 0);
    chk("R1 req_valid", 64'(req_valid), 0);

    // R2 three loads take slots 0,1,2
    for (int k = 0; k < 3; k++) begin
      chk("R2 disp_idx", 64'(disp_idx), 64'(k));
      dispatch(0);
    end
    expect_req(0, 32'h1000, 0);
    expect_req(0, 32'h0100, 0);
    expect_req(0, 32'h0200, 0);
    // R9 addresses in reverse order; R3 younger ready loads stay quiet
    wr_addr(2, 32'h0200);
    wr_addr(1, 32'h0100);
    chk("R3 younger ready, head not", 64'(req_valid), 0);
    wr_addr(0, 32'h1000);
    // R4 head load issues with its address, held while not accepted
    chk("R4 req_valid", 64'(req_valid), 1);
    chk("R4 req_is_store", 64'(req_is_store), 0);
    chk("R4 req_addr", 64'(req_addr), 64'h1000);
    step();
    chk("R4 held", 64'(req_valid), 1);
    req_ready = 1;
    step();
    // R7 no re-issue; premature retire ignored
    chk("R7 no reissue", 64'(req_valid), 0);
    retire();
    chk("R7 retire before done ignored", 64'(req_valid), 0);
    respond();
    chk("R7 done but not retired", 64'(req_valid), 0);
    retire();
    chk("R9 second load addr", 64'(req_addr), 64'h0100);
    step(); respond(); retire();
    chk("R9 third load addr", 64'(req_addr), 64'h0200);
    step(); respond(); retire();
    chk("R2 tail after three", 64'(disp_idx), 3);

    // R5/R6 store at slot 3, load at slot 4
    dispatch(1);
    dispatch(0);
    expect_req(1, 32'h0330, 32'hDEAD);
    expect_req(0, 32'h0440, 0);
    wr_addr(4, 32'h0440);
    chk("R3 ready load behind store", 64'(req_valid), 0);
    wr_addr(3, 32'h0330);
    chk("R5 store without data", 64'(req_valid), 0);
    wr_data(3, 32'hDEAD);
    chk("R5 store without rob_head", 64'(req_valid), 0);
    req_ready = 0;
    rob_head = 1; #1;
    chk("R5 store req_valid", 64'(req_valid), 1);
    chk("R5 store kind", 64'(req_is_store), 1);
    chk("R5 store data", 64'(req_data), 64'hDEAD);
    req_ready = 1;
    step();
    rob_head = 0;
    // R6 store left on accept, load now head
    chk("R6 next head valid", 64'(req_valid), 1);
    chk("R6 next head addr", 64'(req_addr), 64'h0440);
    step(); respond(); retire();

    // R2 fill the queue, then offer one more dispatch
    for (int k = 0; k < DEPTH; k++) dispatch(0);
    chk("R2 full", 64'(disp_ready), 0);
    dispatch(1);
    chk("R2 tail unchanged when full", 64'(disp_idx), 5);
    expect_req(0, 32'h0500, 0);
    wr_addr(5, 32'h0500);
    step(); respond(); retire();
    chk("R2 slot freed", 64'(disp_ready), 1);
    chk("R2 tail still 5", 64'(disp_idx), 5);

    // R8 flush
    flush = 1; step(); flush = 0;
    chk("R8 disp_idx", 64'(disp_idx), 0);
    chk("R8 disp_ready", 64'(disp_ready), 1);
    chk("R8 req_valid", 64'(req_valid), 0);
    dispatch(0);
    expect_req(0, 32'h0777, 0);
    wr_addr(0, 32'h0777);
    chk("R8 fresh entry issues", 64'(req_addr), 64'h0777);
    step(); respond(); retire();
    step();
    chk("R9 all requests seen", 64'(expq.size()), 0);

    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule